// File: doc/BRIEF.md
# Vertical-Crosswise Column Multiplier

This block multiplies two unsigned operands of `WIDTH` bits each and returns a product twice as wide. It first forms every bit-pair partial product `a[i] & b[j]` at once, in a single plane of AND gates. It then sums the partial products by output column, one column for each crosswise diagonal `i + j = k`.

Each column reduces its AND terms and the carries that arrive from the column below. The reduction uses only full adders and half adders. It produces one sum bit, which becomes product bit `k`, and a set of carries of double weight that pass to column `k + 1`. Column `2*WIDTH-1` takes only carries, and whatever carries it produces itself are dropped.

A parameter chooses between two output modes. In the first, the product is driven straight out. In the second, the product passes through one clocked stage, and a valid flag travels with it.

Top module: `vc_mult`

## Requirements
- R1: `product` equals the unsigned arithmetic product `op_a * op_b`, `2*WIDTH` bits wide, for every pair of operand values.
- R2: `product[0]` equals `op_a[0] & op_b[0]`, because column 0 holds a single AND term and receives no carries.
- R3: If either operand is zero, the product is zero.
- R4: With both operands at all ones, the product is `(2^WIDTH - 1)^2`. For `WIDTH = 8` this is `16'hFE01`. Carries generated past the top column are zero and do not disturb the product.
- R5: If one operand equals 1, the product equals the other operand, zero-extended.
- R6: With `REGISTER_OUT = 1`, `product` and `out_valid` take their values on each rising clock edge, from the `op_a`, `op_b` and `in_valid` present at that edge. The register loads on every cycle, so `out_valid` drops to 0 one cycle after `in_valid` drops to 0.
- R7: With `REGISTER_OUT = 1`, holding `rst_n` low across a rising edge forces `out_valid` to 0 and `product` to 0. The reset is synchronous and active low.
- R8: With `REGISTER_OUT = 0`, `product` and `out_valid` follow `op_a`, `op_b` and `in_valid` with no clock edge in between. In this mode `out_valid` equals `in_valid`.
- R9: The structure is built from `WIDTH` alone. A `WIDTH = 16` instance produces correct 32-bit products without any edit to the design.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the optional output stage |
| rst_n | input | 1 | Synchronous active-low reset of the output stage |
| in_valid | input | 1 | Marks the current operands as meaningful |
| op_a | input | WIDTH | Unsigned multiplicand |
| op_b | input | WIDTH | Unsigned multiplier |
| out_valid | output | 1 | Valid flag aligned with `product` |
| product | output | 2*WIDTH | Unsigned product |

## Verification
The embedded assertions assume that `op_a`, `op_b` and `in_valid` are known values, which are never X, whenever `rst_n` is high at a rising edge. The registered checks assume that these inputs are steady around that edge. The bench drives every input on the falling edge and samples the outputs on the next falling edge. It therefore always presents settled values at the rising edge. For the combinational instance it waits a short delay after each change before it samples.

// File: rtl/vc_pkg.sv
// Package vc_pkg
// Purpose : shared elaboration-time helpers for the column multiplier.
// Assumes : n >= 2. Column indices run from 0 up to 2n-1.
package vc_pkg;

    // Number of AND terms that fall on diagonal k of an n x n array.
    function automatic int and_count(int k, int n);
        if (k < 0 || k > 2 * n - 2) return 0;
        return (k < n) ? k + 1 : 2 * n - 1 - k;
    endfunction

    // Total bits entering column k: its AND terms plus carries from k-1.
    // A chain reducing m bits to one sum emits floor(m/2) carries.
    function automatic int col_width(int k, int n);
        int m;
        m = 0;
        for (int c = 0; c <= k; c++) begin
            m = and_count(c, n) + m / 2;
        end
        return m;
    endfunction

    // Carries delivered into column k from column k-1.
    function automatic int carry_in_count(int k, int n);
        return col_width(k - 1, n) / 2;
    endfunction

    // One-bit full adder, returns {carry, sum}.
    function automatic logic [1:0] full_add(logic x, logic y, logic z);
        return {(x & y) | (x & z) | (y & z), x ^ y ^ z};
    endfunction

    // One-bit half adder, returns {carry, sum}.
    function automatic logic [1:0] half_add(logic x, logic y);
        return {x & y, x ^ y};
    endfunction

endpackage

// File: rtl/vc_and_array.sv
// Module vc_and_array
// Purpose : forms all WIDTH*WIDTH partial-product bits in parallel.
// Assumes : bit index i*WIDTH+j of pp carries a[i] & b[j].
module vc_and_array #(
    parameter int WIDTH = 8
) (
    input  logic [WIDTH-1:0]       a,
    input  logic [WIDTH-1:0]       b,
    output logic [WIDTH*WIDTH-1:0] pp
);
    localparam int PP_W = WIDTH * WIDTH;

    // One AND gate for each operand bit pair.
    for (genvar gi = 0; gi < WIDTH; gi++) begin : g_row
        for (genvar gj = 0; gj < WIDTH; gj++) begin : g_col
            assign pp[gi*WIDTH + gj] = a[gi] & b[gj];
        end
    end

    // Check that the flattened plane has the expected size.
    initial begin
        assert (PP_W == $bits(pp)) else $error("pp width mismatch");
    end
endmodule

// File: rtl/vc_column.sv
// Module vc_column
// Purpose : sums one crosswise column (i+j == COL) plus the incoming
//           carries, using a chain of full adders and at most one half
//           adder. Returns the column sum bit and the outgoing carries.
// Assumes : cin holds carry_in_count(COL) valid bits at the bottom and
//           zeros above them. cout is packed the same way.
module vc_column #(
    parameter int WIDTH = 8,
    parameter int COL   = 0
) (
    input  logic [WIDTH*WIDTH-1:0] pp,
    input  logic [2*WIDTH-1:0]     cin,
    output logic                   sum,
    output logic [2*WIDTH-1:0]     cout
);
    import vc_pkg::*;

    localparam int MAXW   = 2 * WIDTH;
    localparam int N_AND  = and_count(COL, WIDTH);
    localparam int N_CIN  = carry_in_count(COL, WIDTH);
    localparam int N_BITS = col_width(COL, WIDTH);

    logic [MAXW-1:0] bits;
    logic            unused_inputs;

    // Gather the diagonal's AND terms, then the arriving carries, into one vector.
    always_comb begin
        int pos;
        bits = '0;
        pos  = 0;
        for (int i = 0; i < WIDTH; i++) begin
            if (COL - i >= 0 && COL - i < WIDTH) begin
                bits[pos] = pp[i*WIDTH + (COL - i)];
                pos = pos + 1;
            end
        end
        for (int t = 0; t < MAXW; t++) begin
            if (t < N_CIN) bits[N_AND + t] = cin[t];
        end
    end

    // Reduce the column with a full-adder chain; each adder emits one carry.
    always_comb begin
        logic       acc;
        logic [1:0] fa;
        acc  = bits[0];
        cout = '0;
        for (int i = 1; i < MAXW; i += 2) begin
            if (i + 1 < N_BITS) begin
                fa = full_add(acc, bits[i], bits[i+1]);
                acc = fa[0];
                cout[(i-1)/2] = fa[1];
            end else if (i < N_BITS) begin
                fa = half_add(acc, bits[i]);
                acc = fa[0];
                cout[(i-1)/2] = fa[1];
            end
        end
        sum = acc;
    end

    // Only one diagonal of pp reaches this column.
    assign unused_inputs = ^{pp, cin};

    // The gathered bits must fit the packed vector.
    initial begin
        assert (N_BITS <= MAXW && N_AND + N_CIN == N_BITS)
            else $error("column %0d sizing", COL);
    end
endmodule

// File: rtl/vc_out_stage.sv
// Module vc_out_stage
// Purpose : optional output register for product and valid flag.
// Assumes : with REG=1 it loads every cycle and resets synchronously
//           on active-low rst_n. With REG=0 it is plain wiring.
module vc_out_stage #(
    parameter int W   = 16,
    parameter bit REG = 1'b1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         in_valid,
    input  logic [W-1:0] d,
    output logic         out_valid,
    output logic [W-1:0] q
);
    if (REG) begin : g_reg
        // Register product and valid, cleared by synchronous reset.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                out_valid <= 1'b0;
                q         <= '0;
            end else begin
                out_valid <= in_valid;
                q         <= d;
            end
        end

        // The valid flag trails the input flag by exactly one cycle.
        assert_valid_follow_R6: assert property (@(posedge clk) disable iff (!rst_n)
            $past(rst_n) |-> (out_valid == $past(in_valid)))
            else $error("out_valid does not follow in_valid");

        // The first edge after reset release shows the cleared register.
        assert_reset_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(rst_n) |-> (!out_valid && q == '0))
            else $error("output stage not cleared by reset");
    end else begin : g_pass
        logic unused_clk;

        // Pass straight through.
        assign out_valid  = in_valid;
        assign q          = d;
        assign unused_clk = clk ^ rst_n;
    end
endmodule

// File: rtl/vc_mult.sv
// Module vc_mult
// Purpose : unsigned WIDTH x WIDTH multiplier. An AND plane feeds
//           2*WIDTH column adders that ripple their carries upward. The
//           product can be sent out through a register stage.
// Assumes : inputs are settled at the rising edge when REGISTER_OUT=1.
module vc_mult #(
    parameter int WIDTH        = 8,
    parameter bit REGISTER_OUT = 1'b1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               in_valid,
    input  logic [WIDTH-1:0]   op_a,
    input  logic [WIDTH-1:0]   op_b,
    output logic               out_valid,
    output logic [2*WIDTH-1:0] product
);
    localparam int PW   = 2 * WIDTH;
    localparam int PP_W = WIDTH * WIDTH;

    logic [PP_W-1:0] pp;
    logic [PW-1:0]   col_sum;
    logic [PW-1:0]   carry_chain [PW+1];
    logic            unused_top_carry;

    vc_and_array #(.WIDTH(WIDTH)) u_and (
        .a  (op_a),
        .b  (op_b),
        .pp (pp)
    );

    assign carry_chain[0] = '0;

    // One column adder per product bit, each fed by the carries of the column below.
    for (genvar gk = 0; gk < PW; gk++) begin : g_colsum
        vc_column #(.WIDTH(WIDTH), .COL(gk)) u_col (
            .pp   (pp),
            .cin  (carry_chain[gk]),
            .sum  (col_sum[gk]),
            .cout (carry_chain[gk+1])
        );
    end

    // The top column's own carries lie beyond the product width and are dropped.
    assign unused_top_carry = ^carry_chain[PW];

    vc_out_stage #(.W(PW), .REG(REGISTER_OUT)) u_out (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .d         (col_sum),
        .out_valid (out_valid),
        .q         (product)
    );

    // The dropped carries are always zero, so nothing is lost by discarding them.
    assert_top_carry_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
        carry_chain[PW] == '0)
        else $error("carry escaped the top column");

    if (REGISTER_OUT) begin : g_chk_reg
        // The registered product matches the operands of the previous edge.
        assert_product_R1: assert property (@(posedge clk) disable iff (!rst_n)
            $past(rst_n) |-> (product == PW'($past(op_a)) * PW'($past(op_b))))
            else $error("registered product wrong");

        // Bit 0 of the product is the lone AND term of column 0.
        assert_lsb_R2: assert property (@(posedge clk) disable iff (!rst_n)
            $past(rst_n) |-> (product[0] == ($past(op_a[0]) & $past(op_b[0]))))
            else $error("product lsb wrong");
    end else begin : g_chk_comb
        // The combinational product matches the present operands.
        assert_product_R8: assert property (@(posedge clk) disable iff (!rst_n)
            (product == PW'(op_a) * PW'(op_b)) && (out_valid == in_valid))
            else $error("combinational product wrong");

        // A zero operand gives a zero product.
        assert_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
            (op_a == '0 || op_b == '0) |-> (product == '0))
            else $error("zero operand gave nonzero product");
    end
endmodule

// File: tb/sim_vc_mult.sv
// Bench for vc_mult. u0 is the registered 8-bit instance and is swept
// exhaustively. u1 is a combinational 16-bit instance, driven with random
// vectors and corner values.
module sim_vc_mult;
    logic clk = 1'b0;
    logic rst_n = 1'b0;

    logic        v0_in = 1'b0;
    logic [7:0]  a0 = '0, b0 = '0;
    logic        v0_out;
    logic [15:0] p0;

    logic        v1_in = 1'b0;
    logic [15:0] a1 = '0, b1 = '0;
    logic        v1_out;
    logic [31:0] p1;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;   // 50 MHz

    vc_mult #(.WIDTH(8), .REGISTER_OUT(1'b1)) u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(v0_in), .op_a(a0), .op_b(b0),
        .out_valid(v0_out), .product(p0));

    vc_mult #(.WIDTH(16), .REGISTER_OUT(1'b0)) u1 (
        .clk(clk), .rst_n(rst_n), .in_valid(v1_in), .op_a(a1), .op_b(b1),
        .out_valid(v1_out), .product(p1));

    task automatic check(string req, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Pick the requirement that names this operand pair best.
    function automatic string tag8(int a, int b);
        if (a == 0 || b == 0) return "R3";
        if (a == 255 && b == 255) return "R4";
        if (a == 1 || b == 1) return "R5";
        return "R1";
    endfunction

    initial begin
        // R7: reset held low while valid inputs are present.
        v0_in = 1'b1; a0 = 8'hFF; b0 = 8'hFF;
        repeat (3) @(negedge clk);
        check("R7 valid in reset", 64'(v0_out), 64'd0);
        check("R7 product in reset", 64'(p0), 64'd0);
        rst_n = 1'b1;

        // R1, R3, R4, R5: exhaustive sweep of the registered 8-bit instance.
        for (int a = 0; a < 256; a++) begin
            for (int b = 0; b < 256; b++) begin
                @(negedge clk);
                a0 = 8'(a); b0 = 8'(b); v0_in = 1'b1;
                @(negedge clk);
                check(tag8(a, b), 64'(p0), 64'(a * b));
                if (b == a) check("R2 lsb", 64'(p0[0]), 64'(a[0] & b[0]));
            end
        end
        check("R4 all ones", 64'(p0), 64'hFE01);
        check("R6 valid high", 64'(v0_out), 64'd1);

        // R6: dropping in_valid clears out_valid one cycle later; the product still loads.
        @(negedge clk);
        v0_in = 1'b0; a0 = 8'd12; b0 = 8'd11;
        check("R6 before edge", 64'(v0_out), 64'd1);
        @(negedge clk);
        check("R6 valid low", 64'(v0_out), 64'd0);
        check("R6 product loads", 64'(p0), 64'd132);

        // R7: synchronous reset after operation clears the stage.
        v0_in = 1'b1;
        rst_n = 1'b0;
        @(negedge clk);
        check("R7 reclear valid", 64'(v0_out), 64'd0);
        check("R7 reclear product", 64'(p0), 64'd0);
        rst_n = 1'b1;

        // R8, R9: combinational 16-bit instance.
        for (int n = 0; n < 3000; n++) begin
            @(negedge clk);
            case (n)
                0: begin a1 = 16'hFFFF; b1 = 16'hFFFF; end
                1: begin a1 = 16'h0000; b1 = 16'hBEEF; end
                2: begin a1 = 16'h0001; b1 = 16'h8001; end
                3: begin a1 = 16'h8000; b1 = 16'h8000; end
                default: begin a1 = 16'($urandom); b1 = 16'($urandom); end
            endcase
            v1_in = n[0];
            #2;
            check("R9 wide product", 64'(p1), 64'(a1) * 64'(b1));
            check("R8 valid passthru", 64'(v1_out), 64'(v1_in));
        end
        check("R8 same-cycle", 64'(p1), 64'(a1) * 64'(b1));

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule